// File: doc/BRIEF.md
# Memory rank sparing controller

This block watches the correctable and uncorrectable error counters of every memory rank and compares them against a threshold that software programs. When sparing is enabled and exactly one rank has reached the threshold, the controller records that rank as failed. It then walks a line address from zero to a fixed last line and asks an external line-copy datapath to move each line from the failed rank to a spare rank. When the last line is acknowledged, it rewrites every rank-mapping table entry that pointed at the failed rank so that it points at the spare.

Three states carry the behaviour. IDLE waits for the trigger. It moves to COPY on the transition "start" when the enable is set, the threshold is nonzero and exactly one rank is at threshold. COPY leaves by "abandon" back to IDLE when the enable is cleared, or by "finish" to DONE when the acknowledge for the last line arrives. DONE leaves by "release" back to IDLE only when the enable is cleared. Disabling during COPY discards the line position, so a later start begins again at line zero. The spare rank field cannot be changed while a copy runs.

Top module: `rank_spare_ctrl`

## Requirements
- R1: After reset, copy_busy, failover_done, copy_req and both event pulses are 0, cfg_rdata is 0, and mapping entry i holds rank index i.
- R2: A cfg_wr write stores cfg_wdata[7:4] as the threshold, cfg_wdata[3:1] as the spare rank and cfg_wdata[0] as the sparing enable; cfg_rdata returns the stored fields in the same bit positions from the next cycle on.
- R3: thr_hit is 1, combinationally, whenever the threshold is nonzero and the correctable or uncorrectable count of at least one rank is greater than or equal to it, and 0 otherwise.
- R4: With the enable set and a nonzero threshold, when exactly one rank is at threshold, copy_busy rises on the next clock edge, evt_copy_start is high for exactly that first busy cycle, and failed_rank holds that rank's index. Two or more ranks at threshold start nothing.
- R5: While copy_busy is 1, copy_req is 1 with copy_src equal to failed_rank and copy_dst equal to the spare rank; copy_line starts at 0, holds until copy_ack, and advances by one per acknowledged line.
- R6: An acknowledge on the last line sets failover_done and clears copy_busy on the same edge, raises evt_failover for one cycle, and on that edge rewrites every mapping entry equal to failed_rank with the spare rank; other entries are unchanged.
- R7: failover_done stays 1, regardless of the counts, until the enable is written 0.
- R8: While copy_busy is 1, a write leaves the spare rank field unchanged while still updating the threshold and enable fields.
- R9: Clearing the enable during a copy returns to idle (copy_busy and copy_req go 0); a later re-enable with the trigger still valid restarts the copy at line 0 with a new evt_copy_start pulse.
- R10: A threshold of 0 never starts a copy, whatever the counts and enable.
- R11: A map_wr write stores map_wdata into mapping entry map_idx, visible on map_flat (entry i at bits [3i+2:3i]) from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data: threshold [7:4], spare [3:1], enable [0] |
| cfg_rdata | output | 8 | Control register readback, same layout |
| ce_cnt | input | 32 | Correctable counts, rank r at [4r+3:4r] |
| ue_cnt | input | 32 | Uncorrectable counts, rank r at [4r+3:4r] |
| map_wr | input | 1 | Mapping table write strobe |
| map_idx | input | MAP_IDX_W | Mapping entry to write |
| map_wdata | input | 3 | Rank index to write |
| map_flat | output | 3*MAP_ENTRIES | All mapping entries, entry i at [3i+2:3i] |
| copy_req | output | 1 | Line copy request |
| copy_src | output | 3 | Source rank of the copy |
| copy_dst | output | 3 | Destination rank of the copy |
| copy_line | output | LINE_W | Line address to copy |
| copy_ack | input | 1 | Line copy done |
| thr_hit | output | 1 | Some rank count has reached the threshold |
| copy_busy | output | 1 | Copy in progress |
| failover_done | output | 1 | Spare has replaced the failed rank |
| failed_rank | output | 3 | Rank captured at copy start |
| evt_copy_start | output | 1 | One-cycle pulse when a copy begins |
| evt_failover | output | 1 | One-cycle pulse when the fail-over completes |

## Verification
The bench builds the block with LAST_LINE = 3 and MAP_ENTRIES = 4, so a whole copy is four acknowledged lines and the finish transition, the abandon in the middle of a walk and the restart from line zero all fit in a few dozen cycles. Four mapping entries let one test hold two entries that name the failed rank next to two that must stay put, which shows the rewrite is selective.

// File: rtl/rank_spare_pkg.sv
package rank_spare_pkg;
    localparam int NUM_RANKS = 8;
    localparam int RANK_W    = 3;
    localparam int THR_W     = 4;

    typedef logic [RANK_W-1:0] rank_t;
    typedef logic [THR_W-1:0]  thr_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_COPY = 2'd1,
        S_DONE = 2'd2
    } spare_state_t;
endpackage

// File: rtl/rank_thresh_detect.sv
module rank_thresh_detect
    import rank_spare_pkg::*;
(
    input  logic [NUM_RANKS*THR_W-1:0] ce_cnt,
    input  logic [NUM_RANKS*THR_W-1:0] ue_cnt,
    input  thr_t                       thresh,
    output logic                       any_hit,
    output logic                       one_hit,
    output rank_t                      hit_rank
);
    logic [NUM_RANKS-1:0] hit;

    generate
        for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
            always_comb begin
                hit[r] = (thresh != '0) &&
                         ((ce_cnt[r*THR_W +: THR_W] >= thresh) ||
                          (ue_cnt[r*THR_W +: THR_W] >= thresh));
            end
        end
    endgenerate

    always_comb begin
        int unsigned cnt;
        cnt      = 0;
        hit_rank = '0;
        for (int r = 0; r < NUM_RANKS; r++) begin
            if (hit[r]) begin
                cnt      = cnt + 1;
                hit_rank = rank_t'(r);
            end
        end
        any_hit = (cnt != 0);
        one_hit = (cnt == 1);
    end

    // R10
    always_comb begin
        zero_thr_chk: assert (thresh != '0 || !any_hit)
            else $error("hit reported with zero threshold");
    end
endmodule

// File: rtl/spare_copy_fsm.sv
module spare_copy_fsm
    import rank_spare_pkg::*;
#(
    parameter int LAST_LINE = 1023,
    parameter int LINE_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              trig,
    input  rank_t             trig_rank,
    input  logic              copy_ack,
    output logic              busy,
    output logic              done,
    output logic              copy_req,
    output logic [LINE_W-1:0] copy_line,
    output rank_t             failed_rank,
    output logic              evt_start,
    output logic              evt_done,
    output logic              remap_go
);
    spare_state_t state, nxt;
    logic [LINE_W-1:0] line_q;
    rank_t             fail_q;
    logic              evt_start_q, evt_done_q;
    logic              last_line;
    logic              start_go;

    assign last_line = (line_q == LINE_W'(LAST_LINE));
    assign start_go  = (state == S_IDLE) && en && trig;
    assign remap_go  = (state == S_COPY) && en && copy_ack && last_line;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (en && trig) nxt = S_COPY;
            S_COPY: begin
                if (!en)                        nxt = S_IDLE;
                else if (copy_ack && last_line) nxt = S_DONE;
            end
            S_DONE: if (!en) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q      <= '0;
            fail_q      <= '0;
            evt_start_q <= 1'b0;
            evt_done_q  <= 1'b0;
        end else begin
            evt_start_q <= start_go;
            evt_done_q  <= remap_go;
            if (start_go) fail_q <= trig_rank;
            if (state != S_COPY || !en) begin
                line_q <= '0;
            end else if (copy_ack) begin
                line_q <= last_line ? '0 : line_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy        = (state == S_COPY);
        done        = (state == S_DONE);
        copy_req    = (state == S_COPY);
        copy_line   = line_q;
        failed_rank = fail_q;
        evt_start   = evt_start_q;
        evt_done    = evt_done_q;
    end

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_start |-> (busy && !$past(busy)))
        else $error("start pulse outside first busy cycle");

    // R5
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_req && !copy_ack && en) |=> (copy_line == $past(copy_line)))
        else $error("line moved without acknowledge");

    // R6
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && evt_done))
        else $error("done set without a finishing copy");

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> !$past(en))
        else $error("done cleared while enabled");

    // R9
    abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en) |=> (!busy && copy_line == '0))
        else $error("copy not abandoned on disable");
endmodule

// File: rtl/rank_map_table.sv
module rank_map_table
    import rank_spare_pkg::*;
#(
    parameter int MAP_ENTRIES = 4,
    parameter int MAP_IDX_W   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          map_wr,
    input  logic [MAP_IDX_W-1:0]          map_idx,
    input  rank_t                         map_wdata,
    input  logic                          remap_go,
    input  rank_t                         old_rank,
    input  rank_t                         new_rank,
    output logic [MAP_ENTRIES*RANK_W-1:0] map_flat
);
    generate
        for (genvar i = 0; i < MAP_ENTRIES; i++) begin : g_ent
            localparam rank_t INIT = rank_t'(i % NUM_RANKS);
            rank_t ent_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_q <= INIT;
                end else if (remap_go && ent_q == old_rank) begin
                    ent_q <= new_rank;
                end else if (map_wr && map_idx == MAP_IDX_W'(i)) begin
                    ent_q <= map_wdata;
                end
            end

            assign map_flat[i*RANK_W +: RANK_W] = ent_q;

            // R6
            remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (remap_go && ent_q == old_rank) |=> (ent_q == $past(new_rank)))
                else $error("mapping entry not redirected");
        end
    endgenerate
endmodule

// File: rtl/rank_spare_ctrl.sv
module rank_spare_ctrl
    import rank_spare_pkg::*;
#(
    parameter int  LAST_LINE   = 1023,
    parameter int  MAP_ENTRIES = 4,
    localparam int LINE_W      = (LAST_LINE < 1) ? 1 : $clog2(LAST_LINE + 1),
    localparam int MAP_IDX_W   = (MAP_ENTRIES < 2) ? 1 : $clog2(MAP_ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr,
    input  logic [7:0]                    cfg_wdata,
    output logic [7:0]                    cfg_rdata,
    input  logic [NUM_RANKS*THR_W-1:0]    ce_cnt,
    input  logic [NUM_RANKS*THR_W-1:0]    ue_cnt,
    input  logic                          map_wr,
    input  logic [MAP_IDX_W-1:0]          map_idx,
    input  logic [RANK_W-1:0]             map_wdata,
    output logic [MAP_ENTRIES*RANK_W-1:0] map_flat,
    output logic                          copy_req,
    output logic [RANK_W-1:0]             copy_src,
    output logic [RANK_W-1:0]             copy_dst,
    output logic [LINE_W-1:0]             copy_line,
    input  logic                          copy_ack,
    output logic                          thr_hit,
    output logic                          copy_busy,
    output logic                          failover_done,
    output logic [RANK_W-1:0]             failed_rank,
    output logic                          evt_copy_start,
    output logic                          evt_failover
);
    thr_t  thr_q;
    rank_t spare_q;
    logic  en_q;
    logic  one_hit;
    rank_t hit_rank;
    logic  remap_go;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q   <= '0;
            spare_q <= '0;
            en_q    <= 1'b0;
        end else if (cfg_wr) begin
            thr_q <= cfg_wdata[7:4];
            en_q  <= cfg_wdata[0];
            if (!copy_busy) spare_q <= cfg_wdata[3:1];
        end
    end

    assign cfg_rdata = {thr_q, spare_q, en_q};

    rank_thresh_detect u_det (
        .ce_cnt   (ce_cnt),
        .ue_cnt   (ue_cnt),
        .thresh   (thr_q),
        .any_hit  (thr_hit),
        .one_hit  (one_hit),
        .hit_rank (hit_rank)
    );

    spare_copy_fsm #(
        .LAST_LINE (LAST_LINE),
        .LINE_W    (LINE_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en_q),
        .trig        (one_hit),
        .trig_rank   (hit_rank),
        .copy_ack    (copy_ack),
        .busy        (copy_busy),
        .done        (failover_done),
        .copy_req    (copy_req),
        .copy_line   (copy_line),
        .failed_rank (failed_rank),
        .evt_start   (evt_copy_start),
        .evt_done    (evt_failover),
        .remap_go    (remap_go)
    );

    assign copy_src = failed_rank;
    assign copy_dst = spare_q;

    rank_map_table #(
        .MAP_ENTRIES (MAP_ENTRIES),
        .MAP_IDX_W   (MAP_IDX_W)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .map_wr    (map_wr),
        .map_idx   (map_idx),
        .map_wdata (map_wdata),
        .remap_go  (remap_go),
        .old_rank  (failed_rank),
        .new_rank  (spare_q),
        .map_flat  (map_flat)
    );

    // R8
    spare_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_busy && cfg_wr) |=> (cfg_rdata[3:1] == $past(cfg_rdata[3:1])))
        else $error("spare field changed during copy");
endmodule

// File: tb/rank_spare_ctrl_test.sv
module rank_spare_ctrl_test;
    localparam int LAST = 3;
    localparam int ENT  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [31:0] ce_cnt = '0;
    logic [31:0] ue_cnt = '0;
    logic        map_wr = 1'b0;
    logic [1:0]  map_idx = '0;
    logic [2:0]  map_wdata = '0;
    logic [11:0] map_flat;
    logic        copy_req;
    logic [2:0]  copy_src, copy_dst;
    logic [1:0]  copy_line;
    logic        copy_ack = 1'b0;
    logic        thr_hit, copy_busy, failover_done;
    logic [2:0]  failed_rank;
    logic        evt_copy_start, evt_failover;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rank_spare_ctrl #(.LAST_LINE(LAST), .MAP_ENTRIES(ENT)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .ce_cnt(ce_cnt), .ue_cnt(ue_cnt),
        .map_wr(map_wr), .map_idx(map_idx), .map_wdata(map_wdata),
        .map_flat(map_flat), .copy_req(copy_req), .copy_src(copy_src),
        .copy_dst(copy_dst), .copy_line(copy_line), .copy_ack(copy_ack),
        .thr_hit(thr_hit), .copy_busy(copy_busy), .failover_done(failover_done),
        .failed_rank(failed_rank), .evt_copy_start(evt_copy_start),
        .evt_failover(evt_failover)
    );

    // {expected thr_hit, threshold, rank, ce, ue}
    localparam logic [16:0] VEC [8] = '{
        {1'b1, 4'd5,  4'd0, 4'd5,  4'd0},
        {1'b0, 4'd5,  4'd3, 4'd4,  4'd4},
        {1'b1, 4'd5,  4'd7, 4'd0,  4'd5},
        {1'b1, 4'd5,  4'd2, 4'd9,  4'd0},
        {1'b0, 4'd15, 4'd4, 4'd14, 4'd0},
        {1'b1, 4'd15, 4'd4, 4'd15, 4'd15},
        {1'b0, 4'd0,  4'd1, 4'd0,  4'd0},
        {1'b1, 4'd1,  4'd6, 4'd0,  4'd1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic map_write(input int idx, input int val);
        @(negedge clk);
        map_wr = 1'b1;
        map_idx = 2'(idx);
        map_wdata = 3'(val);
        @(negedge clk);
        map_wr = 1'b0;
    endtask

    task automatic ack_line();
        @(negedge clk);
        copy_ack = 1'b1;
        @(negedge clk);
        copy_ack = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", copy_busy, 0);
        chk("R1 done", failover_done, 0);
        chk("R1 req", copy_req, 0);
        chk("R1 cfg", cfg_rdata, 0);
        chk("R1 evt", {evt_copy_start, evt_failover}, 0);
        for (int i = 0; i < ENT; i++) chk("R1 map", map_flat[i*3 +: 3], i);

        map_write(3, 1);
        chk("R11 map write", map_flat[9 +: 3], 1);

        for (int k = 0; k < 8; k++) begin
            logic [16:0] v;
            v = VEC[k];
            cfg_write({v[15:12], 3'd0, 1'b0});
            chk("R2 readback", cfg_rdata, {v[15:12], 4'd0});
            ce_cnt = '0;
            ue_cnt = '0;
            ce_cnt[v[10:8]*4 +: 4] = v[7:4];
            ue_cnt[v[10:8]*4 +: 4] = v[3:0];
            #1;
            chk((v[15:12] == 0) ? "R10 thr_hit zero thr" : "R3 thr_hit", thr_hit, v[16]);
        end

        // two ranks at threshold: no start
        ce_cnt = '0;
        ue_cnt = '0;
        ce_cnt[1*4 +: 4] = 4'd5;
        ue_cnt[2*4 +: 4] = 4'd5;
        cfg_write(8'h5D);
        chk("R2 enable write", cfg_rdata, 8'h5D);
        repeat (3) @(negedge clk);
        chk("R4 two ranks no start", copy_busy, 0);
        chk("R3 thr_hit two ranks", thr_hit, 1);

        ue_cnt[2*4 +: 4] = 4'd0;
        @(negedge clk);
        chk("R4 busy", copy_busy, 1);
        chk("R4 start pulse", evt_copy_start, 1);
        chk("R4 failed rank", failed_rank, 1);
        chk("R5 req", copy_req, 1);
        chk("R5 src", copy_src, 1);
        chk("R5 dst", copy_dst, 6);
        chk("R5 line0", copy_line, 0);
        @(negedge clk);
        chk("R4 pulse one cycle", evt_copy_start, 0);
        chk("R5 line held", copy_line, 0);

        cfg_write(8'h3F);
        chk("R8 spare locked", cfg_rdata, 8'h3D);
        cfg_write(8'h5D);

        ack_line();
        chk("R5 line1", copy_line, 1);
        ack_line();
        chk("R5 line2", copy_line, 2);

        cfg_write(8'h5C);
        @(negedge clk);
        chk("R9 abandon busy", copy_busy, 0);
        chk("R9 abandon req", copy_req, 0);
        cfg_write(8'h5D);
        @(negedge clk);
        chk("R9 restart busy", copy_busy, 1);
        chk("R9 restart pulse", evt_copy_start, 1);
        chk("R9 restart line0", copy_line, 0);

        for (int l = 1; l <= LAST; l++) begin
            ack_line();
            chk("R5 walk", copy_line, l);
        end
        chk("R6 not done early", failover_done, 0);
        ack_line();
        chk("R6 done", failover_done, 1);
        chk("R6 busy cleared", copy_busy, 0);
        chk("R6 event", evt_failover, 1);
        chk("R6 map0", map_flat[0 +: 3], 0);
        chk("R6 map1", map_flat[3 +: 3], 6);
        chk("R6 map2", map_flat[6 +: 3], 2);
        chk("R6 map3", map_flat[9 +: 3], 6);
        @(negedge clk);
        chk("R6 event one cycle", evt_failover, 0);

        ack_line();
        ce_cnt = '0;
        repeat (2) @(negedge clk);
        chk("R7 done held", failover_done, 1);
        chk("R7 map stable", map_flat, {3'd6, 3'd2, 3'd6, 3'd0});
        cfg_write(8'h5C);
        @(negedge clk);
        chk("R7 done cleared", failover_done, 0);

        cfg_write(8'h01);
        ce_cnt[0 +: 4] = 4'd3;
        repeat (3) @(negedge clk);
        chk("R10 no start", copy_busy, 0);
        chk("R10 no hit", thr_hit, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule